// File: doc/BRIEF.md
# Direct-Mapped Fetch Cache with Fill Stall

This block sits in front of a small processor's fetch stage and supplies 16-bit instruction words from a direct-mapped cache. Instruction words and their address tags live in one dual-port synchronous RAM. The lower half holds the words and the upper half holds the tags, and both halves are indexed by the same next-PC bits. The block also owns the program counter. Each cycle it forms the next PC from the jump, branch and sequential controls, starts the read for that address, and on the following cycle compares the stored tag with the upper bits of the PC that has just been loaded.

On a mismatch, or when an entry has not been filled since reset, the pipeline enable drops. The PC then holds, so the fetch repeats at the same address. The block raises a fill request that carries the missing address. An outside fill agent answers with one fill strobe and the instruction word. That single write stores the word in the data half and the current tag in the tag half. The read path forwards the new values in the same edge, so the cycle after the fill is a hit.

Top module: `ifetch_cache`

## Requirements
- R1: While `rst` is high, `pipe_en` and `miss_req` are low and `pc` is forced to the reset address (0 by default).
- R2: Reset invalidates every entry. The first cycle after `rst` falls is a miss at the reset address, even if that address was filled before the reset.
- R3: When the valid bit and the stored tag at index `pc[7:1]` match `pc[15:8]`, `pipe_en` is high and `insn` shows the word last filled for that address, with no new fill request.
- R4: On a miss, `pipe_en` is low, `miss_req` is high, `miss_addr` equals `pc`, and `pc` holds its value until the entry is filled.
- R5: A fill strobe during a miss writes `fill_insn` and the tag of `pc` into the entry at `pc[7:1]`. The next cycle is a hit and shows that word on `insn`.
- R6: A fill strobe while `miss_req` is low has no effect: every word that is read back afterwards is the one filled on its own miss.
- R7: When enabled with neither jump nor branch requested, the next `pc` is `pc + 2`.
- R8: When enabled, a jump-and-link loads `jmp_target` and takes priority over a branch. A taken branch loads `pc` plus the sign-extended `br_disp` shifted left by one.
- R9: Addresses that differ only in the tag bits `pc[15:8]` share one entry. Filling one of them evicts the other, so the next fetch of the other misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| jmp_link | input | 1 | Jump-and-link: next PC is `jmp_target` |
| jmp_target | input | ADDR_W (16) | Jump destination address |
| br_taken | input | 1 | Taken branch: next PC is PC plus twice `br_disp` |
| br_disp | input | DISP_W (8) | Signed branch displacement in halfwords |
| fill_valid | input | 1 | Fill strobe from the outside agent |
| fill_insn | input | 16 | Instruction word written on a fill |
| pc | output | ADDR_W (16) | Current fetch address |
| insn | output | 16 | Instruction word for `pc`, valid while `pipe_en` is high |
| pipe_en | output | 1 | Pipeline clock enable; low on reset or miss |
| miss_req | output | 1 | Fill request, high while the current fetch misses |
| miss_addr | output | ADDR_W (16) | Address whose word is requested |

## Verification
The bench builds the block with its default values: 16-bit addresses, 128 lines and an 8-bit displacement. This selects the zero-extended tag variant. With only 128 lines, an address 0x0100 apart reaches the same entry as address 0, so eviction and refill come into reach with a few jumps. A jump into the 0xFF00 page stores the widest tag the variant can hold. A negative branch displacement exercises the sign extension of the next-PC adder. A reset partway through the run checks that a line filled before it is requested again.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
   localparam int unsigned WORD_W = 16;
   typedef logic [WORD_W-1:0] word_t;

   function automatic int unsigned tag_width(input int unsigned addr_w, input int unsigned idx_w);
      return addr_w - idx_w - 1;
   endfunction
endpackage

// File: rtl/ifc_dpram.sv
module ifc_dpram #(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic [AW-1:0] a_addr,
   input  logic          a_we,
   input  logic [DW-1:0] a_wd,
   output logic [DW-1:0] a_rd,
   input  logic [AW-1:0] b_addr,
   input  logic          b_we,
   input  logic [DW-1:0] b_wd,
   output logic [DW-1:0] b_rd
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   // write-first on each port: a write is visible on the same port's read data
   always_ff @(posedge clk) begin
      if (a_we) begin
         mem[a_addr] <= a_wd;
         a_rd        <= a_wd;
      end else begin
         a_rd <= mem[a_addr];
      end
      if (b_we) begin
         mem[b_addr] <= b_wd;
         b_rd        <= b_wd;
      end else begin
         b_rd <= mem[b_addr];
      end
   end

   ports_disjoint_chk: assert property (@(posedge clk)
      (a_we && b_we) |-> (a_addr != b_addr));
endmodule

// File: rtl/ifc_next_pc.sv
module ifc_next_pc #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DISP_W   = 8,
   parameter int unsigned RESET_PC = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pipe_en,
   input  logic              jmp_link,
   input  logic [ADDR_W-1:0] jmp_target,
   input  logic              br_taken,
   input  logic [DISP_W-1:0] br_disp,
   output logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] pc_nxt
);
   localparam logic [ADDR_W-1:0] PC_INIT = ADDR_W'(RESET_PC);
   localparam int unsigned       EXT_W   = ADDR_W - DISP_W - 1;

   logic [ADDR_W-1:0] disp_ext;

   assign disp_ext = {{EXT_W{br_disp[DISP_W-1]}}, br_disp, 1'b0};

   always_comb begin
      if (rst)            pc_nxt = PC_INIT;
      else if (!pipe_en)  pc_nxt = pc;
      else if (jmp_link)  pc_nxt = jmp_target;
      else if (br_taken)  pc_nxt = pc + disp_ext;
      else                pc_nxt = pc + ADDR_W'(2);
   end

   always_ff @(posedge clk) begin
      if (rst) pc <= PC_INIT;
      else     pc <= pc_nxt;
   end

   // R4
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !pipe_en |=> (pc == $past(pc)));
   // R7
   seq_step_chk: assert property (@(posedge clk) disable iff (rst)
      (pipe_en && !jmp_link && !br_taken) |=> (pc == $past(pc) + ADDR_W'(2)));
   // R8
   jump_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (pipe_en && jmp_link) |=> (pc == $past(jmp_target)));
endmodule

// File: rtl/ifc_tag_check.sv
module ifc_tag_check
   import ifc_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned IDX_W  = 7
) (
   input  logic                                    clk,
   input  logic                                    rst,
   input  logic [IDX_W-1:0]                        idx,
   input  logic                                    wr_en,
   input  logic [tag_width(ADDR_W, IDX_W)-1:0]     pc_tag,
   input  word_t                                   tag_rd,
   output word_t                                   tag_wd,
   output logic                                    hit
);
   localparam int unsigned TAG_W = tag_width(ADDR_W, IDX_W);
   localparam int unsigned LINES = 1 << IDX_W;

   logic [LINES-1:0] valid;
   logic             valid_q;

   // valid bits kept in flops so reset clears every line in one cycle
   always_ff @(posedge clk) begin
      if (rst) begin
         valid   <= '0;
         valid_q <= 1'b0;
      end else begin
         if (wr_en) valid[idx] <= 1'b1;
         valid_q <= valid[idx] | wr_en;
      end
   end

   generate
      if (TAG_W < WORD_W) begin : g_narrow_tag
         assign tag_wd = {{(WORD_W-TAG_W){1'b0}}, pc_tag};
      end else begin : g_full_tag
         assign tag_wd = pc_tag;
      end
   endgenerate

   assign hit = valid_q && (tag_rd == tag_wd);

   // R2
   reset_invalid_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> !hit);
endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache
   import ifc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned LINES    = 128,
   parameter int unsigned DISP_W   = 8,
   parameter int unsigned RESET_PC = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              jmp_link,
   input  logic [ADDR_W-1:0] jmp_target,
   input  logic              br_taken,
   input  logic [DISP_W-1:0] br_disp,
   input  logic              fill_valid,
   input  logic [15:0]       fill_insn,
   output logic [ADDR_W-1:0] pc,
   output logic [15:0]       insn,
   output logic              pipe_en,
   output logic              miss_req,
   output logic [ADDR_W-1:0] miss_addr
);
   localparam int unsigned IDX_W   = $clog2(LINES);
   localparam int unsigned TAG_W   = tag_width(ADDR_W, IDX_W);
   localparam int unsigned TAG_LSB = IDX_W + 1;

   generate
      if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
         $error("LINES must be a power of two of at least 2");
      end
      if (TAG_W < 1 || TAG_W > WORD_W) begin : g_bad_tag
         $error("tag must fit in one RAM word");
      end
      if (ADDR_W <= DISP_W + 1) begin : g_bad_disp
         $error("displacement too wide for the address");
      end
   endgenerate

   logic [ADDR_W-1:0] pc_nxt;
   logic [IDX_W-1:0]  idx;
   word_t             insn_rd, tag_rd, tag_wd;
   logic              hit, fill_we;
   logic              unused_nxt_bits;

   // while stalled pc_nxt equals pc, so the read index is also the fill index
   assign idx             = pc_nxt[IDX_W:1];
   assign unused_nxt_bits = ^{pc_nxt[ADDR_W-1:TAG_LSB], pc_nxt[0]};

   assign pipe_en   = !rst && hit;
   assign miss_req  = !rst && !hit;
   assign miss_addr = pc;
   assign fill_we   = fill_valid && miss_req;
   assign insn      = insn_rd;

   ifc_next_pc #(
      .ADDR_W   (ADDR_W),
      .DISP_W   (DISP_W),
      .RESET_PC (RESET_PC)
   ) u_pc (
      .clk        (clk),
      .rst        (rst),
      .pipe_en    (pipe_en),
      .jmp_link   (jmp_link),
      .jmp_target (jmp_target),
      .br_taken   (br_taken),
      .br_disp    (br_disp),
      .pc         (pc),
      .pc_nxt     (pc_nxt)
   );

   ifc_dpram #(
      .AW (IDX_W + 1),
      .DW (WORD_W)
   ) u_ram (
      .clk    (clk),
      .a_addr ({1'b0, idx}),
      .a_we   (fill_we),
      .a_wd   (fill_insn),
      .a_rd   (insn_rd),
      .b_addr ({1'b1, idx}),
      .b_we   (fill_we),
      .b_wd   (tag_wd),
      .b_rd   (tag_rd)
   );

   ifc_tag_check #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
   ) u_tag (
      .clk    (clk),
      .rst    (rst),
      .idx    (idx),
      .wr_en  (fill_we),
      .pc_tag (pc[ADDR_W-1:TAG_LSB]),
      .tag_rd (tag_rd),
      .tag_wd (tag_wd),
      .hit    (hit)
   );

   // R5
   fill_then_hit_chk: assert property (@(posedge clk) disable iff (rst)
      fill_we |=> (pipe_en && insn == $past(fill_insn)));
   // R4
   miss_persists_chk: assert property (@(posedge clk) disable iff (rst)
      (miss_req && !fill_valid) |=> (miss_req && $stable(miss_addr)));
endmodule

// File: tb/ifetch_cache_test.sv
module ifetch_cache_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        jmp_link = 1'b0;
   logic [15:0] jmp_target = '0;
   logic        br_taken = 1'b0;
   logic [7:0]  br_disp = '0;
   logic        fill_valid = 1'b0;
   logic [15:0] fill_insn = '0;
   logic [15:0] pc, insn, miss_addr;
   logic        pipe_en, miss_req;

   int          checks = 0;
   int          fails = 0;
   int          misses = 0;
   int          cyc = 0;
   bit          inject = 1'b0;
   bit          saw = 1'b0;
   bit          stalled_prev = 1'b0;
   logic [15:0] prev_pc = '0;
   logic [15:0] exp_pc = '0;
   logic [15:0] q[$];
   int          m0, m1;

   always #4 clk = ~clk;

   ifetch_cache uut (
      .clk(clk), .rst(rst), .jmp_link(jmp_link), .jmp_target(jmp_target),
      .br_taken(br_taken), .br_disp(br_disp), .fill_valid(fill_valid),
      .fill_insn(fill_insn), .pc(pc), .insn(insn), .pipe_en(pipe_en),
      .miss_req(miss_req), .miss_addr(miss_addr)
   );

   function automatic logic [15:0] pat(input logic [15:0] a);
      return {a[7:0], a[15:8]} ^ 16'h3C5A;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   // fill agent: answers a miss one cycle after seeing it; can inject a stray strobe
   always @(negedge clk) begin
      #2;
      if (inject) begin
         fill_valid = 1'b1;
         fill_insn  = 16'hDEAD;
         inject     = 1'b0;
         saw        = 1'b0;
      end else if (miss_req && saw) begin
         fill_valid = 1'b1;
         fill_insn  = pat(miss_addr);
         misses++;
         saw        = 1'b0;
      end else begin
         fill_valid = 1'b0;
         saw        = miss_req;
      end
   end

   // monitor: pops the expected PC of every enabled cycle and compares
   always @(negedge clk) begin
      #1;
      if (!rst) begin
         if (pipe_en) begin
            if (q.size() == 0) begin
               chk(1'b0, "R7 unexpected advance", 32'(pc), 32'hFFFFFFFF);
            end else begin
               logic [15:0] e;
               e = q.pop_front();
               chk(pc == e, "R7 pc order", 32'(pc), 32'(e));
               chk(insn == pat(e), "R3 hit word", 32'(insn), 32'(pat(e)));
            end
         end else if (stalled_prev) begin
            chk(pc == prev_pc, "R4 pc holds", 32'(pc), 32'(prev_pc));
         end
         stalled_prev = !pipe_en;
         prev_pc      = pc;
      end else begin
         stalled_prev = 1'b0;
      end
   end

   // driver: one call per enabled cycle; pushes the expected PC, drives controls
   task automatic tick(input bit jl, input logic [15:0] tgt, input bit br,
                       input logic [7:0] d, input bit inj);
      @(negedge clk);
      while (!pipe_en) @(negedge clk);
      q.push_back(exp_pc);
      jmp_link   = jl;
      jmp_target = tgt;
      br_taken   = br;
      br_disp    = d;
      inject     = inj;
      if (jl)      exp_pc = tgt;                                   // R8 jump wins
      else if (br) exp_pc = exp_pc + {{7{d[7]}}, d, 1'b0};         // R8 branch
      else         exp_pc = exp_pc + 16'd2;                        // R7
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) begin
         @(negedge clk);
         #1;
         chk(!pipe_en, "R1 enable low", 32'(pipe_en), 32'd0);
         chk(!miss_req, "R1 no request", 32'(miss_req), 32'd0);
         chk(pc == 16'h0000, "R1 pc reset", 32'(pc), 32'd0);
      end
      @(negedge clk);
      rst    = 1'b0;
      exp_pc = 16'h0000;
      @(negedge clk);
      #3;
      chk(miss_req, "R2 first fetch misses", 32'(miss_req), 32'd1);
      chk(!pipe_en, "R4 stalled", 32'(pipe_en), 32'd0);
      chk(miss_addr == 16'h0000, "R4 miss address", 32'(miss_addr), 32'd0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         checks++;
         fails++;
         $display("FAIL watchdog R4 stall never released act=%0d exp=%0d", cyc, 20000);
         summary();
         $finish;
      end
   end

   initial begin
      do_reset();
      // R7: straight-line fetch 0..14, every line fills on its own miss
      for (int i = 0; i < 8; i++) tick(1'b0, 16'h0, 1'b0, 8'h0, 1'b0);
      tick(1'b1, 16'h0000, 1'b0, 8'h0, 1'b0);   // R8 jump back from 16
      m0 = misses;
      // R3: second pass hits; R6: stray strobe while fetching 6
      for (int i = 0; i < 8; i++) tick(1'b0, 16'h0, 1'b0, 8'h0, i == 3);
      tick(1'b0, 16'h0, 1'b1, 8'hFB, 1'b0);     // R8 branch -5 from 16 lands at 6
      tick(1'b0, 16'h0, 1'b0, 8'h0, 1'b0);      // R6 word at 6 is still the filled one
      chk(misses == m0, "R3 no refill on hits", 32'(misses), 32'(m0));
      // R8: jump and branch together, jump wins
      tick(1'b1, 16'h0100, 1'b1, 8'h04, 1'b0);
      tick(1'b1, 16'h0000, 1'b0, 8'h0, 1'b0);   // 0x0100 evicts 0
      tick(1'b0, 16'h0, 1'b1, 8'h03, 1'b0);     // R9 0 misses again, branch +3 to 6
      chk(misses == m0 + 2, "R9 alias refill", 32'(misses), 32'(m0 + 2));
      tick(1'b1, 16'hFF0E, 1'b0, 8'h0, 1'b0);
      tick(1'b0, 16'h0, 1'b0, 8'h0, 1'b0);      // widest tag 0xFF
      tick(1'b0, 16'h0, 1'b0, 8'h0, 1'b0);
      m1 = misses;
      chk(m1 == m0 + 4, "R9 high page fills", 32'(m1), 32'(m0 + 4));
      // R2: reset forgets line 0 although it was valid
      do_reset();
      tick(1'b0, 16'h0, 1'b0, 8'h0, 1'b0);
      chk(misses == m1 + 1, "R2 refill after reset", 32'(misses), 32'(m1 + 1));
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk(q.size() == 0, "R7 all expected fetches seen", 32'(q.size()), 32'd0);
      summary();
      $finish;
   end
endmodule